// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block holds a 256-entry group-address hash table as eight 32-bit words and decides whether a received multicast destination address should be accepted. Software can write and read any word of the table directly. A command port takes a 48-bit address together with a join or leave flag, hashes the address and then sets or clears the one table bit that the hash selects. A lookup port takes a destination address with a valid strobe and returns an accept flag after a fixed latency.

Both commands and lookups go through one shared hash engine, which is driven by a three-state controller. `ST_IDLE` waits for a request. A request moves it to `ST_HASH`, and when both request strobes are high together the command is taken. `ST_HASH` folds in one address byte per clock for six clocks and then moves to `ST_FINISH`. `ST_FINISH` applies the table update or evaluates the lookup, pulses the done flag that matches the request, and returns to `ST_IDLE`. The busy flag is high in every state except `ST_IDLE`.

The hash runs a reflected CRC-32 with polynomial 0xEDB88320 over the address. The CRC is seeded with all ones and takes each byte least-significant bit first. There is no final inversion. The 32-bit remainder is bit-reversed and its top 8 bits form the table index.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table words read as zero, busy is low, and no done or accept flag is high.
- R2: A register write stores `reg_wdata` into the word selected by `reg_addr` at the clock edge. `reg_rdata` always shows the word that `reg_addr` currently selects.
- R3: The address is sent first byte first, with the first byte at `[47:40]`. The hash is a CRC-32 seeded with 0xFFFFFFFF that shifts right with polynomial 0xEDB88320 and feeds each byte LSB first. The remainder is not complemented. It is bit-reversed over all 32 bits, and bits [31:24] of the reversed value form the 8-bit index.
- R4: Index bits [7:5] select the word. Index bits [4:0] select bit (31 − field) within that word, so entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7.
- R5: A join command sets the selected bit and changes no other bit of the table.
- R6: A leave command clears the selected bit and changes no other bit of the table.
- R7: `lkp_accept` is high only together with `lkp_done`. It is high exactly when the address's group bit (bit 40, the LSB of the first byte) is 1 and the selected table bit is 1.
- R8: A request is taken at a clock edge while busy is low. Busy is then high from that edge until the done pulse. The one-cycle `cmd_done` or `lkp_done` pulse appears after the 7th clock edge that follows the taking edge, and busy is low in that cycle.
- R9: Requests made while busy is high are ignored. If a command and a lookup are both requested in the same idle cycle, the command is taken and the lookup is dropped.
- R10: When a register write and a command update hit the same word at the same edge, the word takes the written data, except that the command's bit takes the join or leave value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for a table word |
| reg_addr | input | 3 | Word select for both read and write |
| reg_wdata | input | 32 | Data for a table word write |
| reg_rdata | output | 32 | Contents of the selected word |
| cmd_valid | input | 1 | Join/leave command request |
| cmd_join | input | 1 | 1 = join (set bit), 0 = leave (clear bit) |
| cmd_mac | input | 48 | Command address, first byte in [47:40] |
| cmd_done | output | 1 | One-cycle pulse when the table update is done |
| lkp_valid | input | 1 | Lookup request |
| lkp_mac | input | 48 | Destination address to check, first byte in [47:40] |
| lkp_done | output | 1 | One-cycle pulse when the lookup result is ready |
| lkp_accept | output | 1 | Accept result, valid with lkp_done |
| busy | output | 1 | A request is in progress |

## Verification
Directed joins on an empty table check that exactly one bit appears, at the position the independent hash model predicts. Leaves on an all-ones table check that exactly one bit disappears. Together these separate errors in the word select, the bit direction and the CRC itself. Lookups are run on an all-ones table with the group bit set and with it clear, which separates the group-bit gate from the table bit. A randomly seeded run of joins, leaves and lookups over a small pool of addresses then compares every result and the final table against a shadow model. Timed collisions check the ordering rules: a register write at the same edge as the update, a command and a lookup raised together, and a request raised while busy.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HASH   = 2'd1,
        ST_FINISH = 2'd2
    } mhf_state_t;

    typedef enum logic {
        OP_LOOKUP  = 1'b0,
        OP_COMMAND = 1'b1
    } mhf_op_t;

    // Fold one byte, LSB first, into a right-shifting CRC-32 remainder.
    function automatic logic [31:0] crc_fold_byte(input logic [31:0] rem,
                                                  input logic [7:0]  data);
        logic [31:0] r;
        r = rem ^ {24'd0, data};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 8,
    localparam int MAC_W     = 8 * ADDR_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [MAC_W-1:0] mac_in,
    output logic [IDX_W-1:0] index
);

    logic [MAC_W-1:0] shift_q;
    logic [31:0]      rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            rem_q   <= CRC_SEED;
        end else if (start) begin
            shift_q <= mac_in;
            rem_q   <= CRC_SEED;
        end else if (step) begin
            rem_q   <= crc_fold_byte(rem_q, shift_q[MAC_W-1 -: 8]);
            shift_q <= shift_q << 8;
        end
    end

    // Top bits of the bit-reversed remainder are the low remainder bits, mirrored.
    for (genvar k = 0; k < IDX_W; k++) begin : g_rev
        assign index[IDX_W-1-k] = rem_q[k];
    end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int SEL_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              upd_en,
    input  logic              upd_set,
    input  logic [SEL_W-1:0]  upd_sel,
    input  logic [BIT_W-1:0]  upd_bit,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  probe_sel,
    input  logic [BIT_W-1:0]  probe_bit,
    output logic              probe_val
);

    logic [WORD_W-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_d;

        always_comb begin
            word_d = word_q[w];
            if (wr_en && (wr_sel == SEL_W'(w))) begin
                word_d = wr_data;
            end
            // Command update is applied last so it wins on its own bit.
            if (upd_en && (upd_sel == SEL_W'(w))) begin
                word_d[upd_bit] = upd_set;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else begin
                word_q[w] <= word_d;
            end
        end
    end

    assign rd_data   = word_q[rd_sel];
    assign probe_val = word_q[probe_sel][probe_bit];

endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_join,
    input  logic lkp_valid,
    input  logic grp_in,
    input  logic hit,
    output logic start,
    output logic step,
    output logic apply_cmd,
    output logic join_q,
    output logic busy,
    output logic cmd_done,
    output logic lkp_done,
    output logic lkp_accept
);

    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(ADDR_BYTES - 1);

    mhf_state_t state_q, state_d;
    mhf_op_t    op_q;
    logic [CNT_W-1:0] cnt_q;
    logic       grp_q;
    logic       finish;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid || lkp_valid) state_d = ST_HASH;
            ST_HASH:   if (cnt_q == LAST_BYTE)     state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign start     = (state_q == ST_IDLE) && (cmd_valid || lkp_valid);
    assign step      = (state_q == ST_HASH);
    assign finish    = (state_q == ST_FINISH);
    assign busy      = (state_q != ST_IDLE);
    assign apply_cmd = finish && (op_q == OP_COMMAND);

    // Output and context register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            op_q       <= OP_LOOKUP;
            join_q     <= 1'b0;
            grp_q      <= 1'b0;
            cmd_done   <= 1'b0;
            lkp_done   <= 1'b0;
            lkp_accept <= 1'b0;
        end else begin
            cmd_done   <= apply_cmd;
            lkp_done   <= finish && (op_q == OP_LOOKUP);
            lkp_accept <= finish && (op_q == OP_LOOKUP) && grp_q && hit;
            if (start) begin
                cnt_q  <= '0;
                op_q   <= cmd_valid ? OP_COMMAND : OP_LOOKUP;
                join_q <= cmd_join;
                grp_q  <= grp_in;
            end else if (step) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int WORDS      = 8,
    parameter int WORD_W     = 32,
    parameter int ADDR_BYTES = 6,
    localparam int SEL_W     = $clog2(WORDS),
    localparam int BIT_W     = $clog2(WORD_W),
    localparam int IDX_W     = SEL_W + BIT_W,
    localparam int MAC_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_join,
    input  logic [MAC_W-1:0]  cmd_mac,
    output logic              cmd_done,
    input  logic              lkp_valid,
    input  logic [MAC_W-1:0]  lkp_mac,
    output logic              lkp_done,
    output logic              lkp_accept,
    output logic              busy
);

    logic              start, step, apply_cmd, join_q, hit;
    logic [MAC_W-1:0]  sel_mac;
    logic [IDX_W-1:0]  index;
    logic [SEL_W-1:0]  word_sel;
    logic [BIT_W-1:0]  bit_pos;

    assign sel_mac  = cmd_valid ? cmd_mac : lkp_mac;
    assign word_sel = index[IDX_W-1 -: SEL_W];
    assign bit_pos  = BIT_W'(WORD_W - 1) - index[BIT_W-1:0];

    mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_join   (cmd_join),
        .lkp_valid  (lkp_valid),
        .grp_in     (sel_mac[MAC_W-8]),
        .hit        (hit),
        .start      (start),
        .step       (step),
        .apply_cmd  (apply_cmd),
        .join_q     (join_q),
        .busy       (busy),
        .cmd_done   (cmd_done),
        .lkp_done   (lkp_done),
        .lkp_accept (lkp_accept)
    );

    mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .step   (step),
        .mac_in (sel_mac),
        .index  (index)
    );

    mhf_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_addr),
        .wr_data   (reg_wdata),
        .upd_en    (apply_cmd),
        .upd_set   (join_q),
        .upd_sel   (word_sel),
        .upd_bit   (bit_pos),
        .rd_sel    (reg_addr),
        .rd_data   (reg_rdata),
        .probe_sel (word_sel),
        .probe_bit (bit_pos),
        .probe_val (hit)
    );

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int SEL_W  = 3,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [SEL_W-1:0]  reg_addr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              cmd_valid,
    input logic              lkp_valid,
    input logic              cmd_done,
    input logic              lkp_done,
    input logic              lkp_accept,
    input logic              busy
);

    assert_accept_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_accept |-> lkp_done);

    assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && lkp_done));

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done || lkp_done) |=> !(cmd_done || lkp_done));

    assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done || lkp_done) |-> !busy);

    assert_request_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (cmd_valid || lkp_valid)) |=> busy);

    assert_table_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(reg_addr) && !$past(reg_wr_en) && !cmd_done) |-> $stable(reg_rdata));

endmodule

bind mcast_hash_filter mhf_checker #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_mhf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .cmd_valid  (cmd_valid),
    .lkp_valid  (lkp_valid),
    .cmd_done   (cmd_done),
    .lkp_done   (lkp_done),
    .lkp_accept (lkp_accept),
    .busy       (busy)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_join = 1'b0;
    logic [47:0] cmd_mac = '0;
    logic        cmd_done;
    logic        lkp_valid = 1'b0;
    logic [47:0] lkp_mac = '0;
    logic        lkp_done;
    logic        lkp_accept;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;
    int n_cmd_done = 0;
    int n_lkp_done = 0;
    logic [31:0] model [8];
    logic [47:0] pool [8];

    always #4 clk = ~clk;

    mcast_hash_filter u_mcast_hash_filter (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_join(cmd_join), .cmd_mac(cmd_mac), .cmd_done(cmd_done),
        .lkp_valid(lkp_valid), .lkp_mac(lkp_mac), .lkp_done(lkp_done), .lkp_accept(lkp_accept),
        .busy(busy)
    );

    always @(negedge clk) begin
        if (cmd_done) n_cmd_done++;
        if (lkp_done) n_lkp_done++;
    end

    function automatic logic [7:0] ref_index(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int n = 0; n < 6; n++) begin
            b = a[47 - 8*n -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ b[i];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        for (int k = 0; k < 32; k++) r[31-k] = c[k];
        return r[31:24];
    endfunction

    function automatic int ref_word(input logic [47:0] a);
        logic [7:0] ix;
        ix = ref_index(a);
        return int'(ix[7:5]);
    endfunction

    function automatic int ref_bit(input logic [47:0] a);
        logic [7:0] ix;
        ix = ref_index(a);
        return 31 - int'(ix[4:0]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int w, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'(w); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model[w] = d;
    endtask

    task automatic read_word(input int w, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(w);
        #1 d = reg_rdata;
    endtask

    task automatic check_table(input string req);
        logic [31:0] d;
        for (int w = 0; w < 8; w++) begin
            read_word(w, d);
            check(req, d, model[w]);
        end
    endtask

    // Runs a command or lookup; checks the done pulse lands 7 edges after acceptance.
    task automatic run_op(input bit is_cmd, input logic [47:0] a, input bit join_f,
                          output bit acc);
        bit early;
        early = 1'b0;
        @(negedge clk);
        if (is_cmd) begin cmd_valid = 1'b1; cmd_mac = a; cmd_join = join_f; end
        else        begin lkp_valid = 1'b1; lkp_mac = a; end
        @(negedge clk);
        cmd_valid = 1'b0; lkp_valid = 1'b0;
        check("R8 busy after accept", {31'd0, busy}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (cmd_done || lkp_done) early = 1'b1;
        end
        @(negedge clk);
        check("R8 no early done", {31'd0, early}, 32'd0);
        check("R8 done at latency", {31'd0, (is_cmd ? cmd_done : lkp_done)}, 32'd1);
        check("R8 idle at done", {31'd0, busy}, 32'd0);
        acc = lkp_accept;
        if (is_cmd) begin
            if (join_f) model[ref_word(a)][ref_bit(a)] = 1'b1;
            else        model[ref_word(a)][ref_bit(a)] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit acc;
        logic [31:0] d;
        logic [47:0] a;
        int cd0, ld0, w, b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 busy low", {31'd0, busy}, 32'd0);
        check("R1 flags low", {29'd0, cmd_done, lkp_done, lkp_accept}, 32'd0);
        check_table("R1 table zero");

        // R2: write/readback
        for (int i = 0; i < 8; i++) reg_write(i, 32'hA5000000 | 32'(i * 32'h01010101));
        check_table("R2 readback");

        // R1: reset clears written table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = '0;
        check_table("R1 reset clears");

        // R3 R4 R5: join on empty table sets exactly the predicted bit
        a = 48'h01005E0000FB;
        run_op(1'b1, a, 1'b1, acc);
        check_table("R3 R4 R5 join single bit");
        a = 48'h333300000001;
        run_op(1'b1, a, 1'b1, acc);
        check_table("R5 second join");

        // R6: leave on full table clears exactly one bit
        for (int i = 0; i < 8; i++) reg_write(i, 32'hFFFFFFFF);
        a = 48'h01005E7FFFFA;
        run_op(1'b1, a, 1'b0, acc);
        check_table("R6 leave single bit");

        // R7: group gate on all-ones table
        for (int i = 0; i < 8; i++) reg_write(i, 32'hFFFFFFFF);
        run_op(1'b0, 48'h0180C2000001, 1'b0, acc);
        check("R7 group set, bit set", {31'd0, acc}, 32'd1);
        run_op(1'b0, 48'h0080C2000001, 1'b0, acc);
        check("R7 group clear", {31'd0, acc}, 32'd0);
        for (int i = 0; i < 8; i++) reg_write(i, 32'h0);
        run_op(1'b0, 48'h0180C2000001, 1'b0, acc);
        check("R7 bit clear", {31'd0, acc}, 32'd0);

        // R10: register write collides with join on same word
        a = 48'h01005E010203;
        w = ref_word(a); b = ref_bit(a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mac = a; cmd_join = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (6) @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'(w); reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model[w] = 32'h0; model[w][b] = 1'b1;
        check_table("R10 join over write");
        // R10: leave collides with all-ones write
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mac = a; cmd_join = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (6) @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'(w); reg_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model[w] = 32'hFFFFFFFF; model[w][b] = 1'b0;
        check_table("R10 leave over write");

        // R9: command and lookup together: command wins
        for (int i = 0; i < 8; i++) reg_write(i, 32'h0);
        cd0 = n_cmd_done; ld0 = n_lkp_done;
        a = 48'h01005E112233;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mac = a; cmd_join = 1'b1;
        lkp_valid = 1'b1; lkp_mac = a;
        @(negedge clk);
        cmd_valid = 1'b0; lkp_valid = 1'b0;
        repeat (10) @(negedge clk);
        model[ref_word(a)][ref_bit(a)] = 1'b1;
        check("R9 command taken", 32'(n_cmd_done - cd0), 32'd1);
        check("R9 lookup dropped", 32'(n_lkp_done - ld0), 32'd0);
        check_table("R9 collision table");

        // R9: command raised while busy with a lookup is ignored
        cd0 = n_cmd_done; ld0 = n_lkp_done;
        @(negedge clk);
        lkp_valid = 1'b1; lkp_mac = a;
        @(negedge clk);
        lkp_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mac = 48'h01005E445566; cmd_join = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 busy command ignored", 32'(n_cmd_done - cd0), 32'd0);
        check("R9 lookup completed", 32'(n_lkp_done - ld0), 32'd1);
        check_table("R9 busy table unchanged");

        // Random mix against the shadow model
        for (int i = 0; i < 8; i++) begin
            pool[i] = {$urandom(), $urandom()} & 48'hFFFFFFFFFFFF;
            pool[i][40] = (i < 6);
        end
        for (int n = 0; n < 60; n++) begin
            logic [47:0] ra;
            ra = pool[$urandom_range(0, 7)];
            if ($urandom_range(0, 1) == 0) begin
                run_op(1'b1, ra, 1'($urandom_range(0, 1)), acc);
            end else begin
                run_op(1'b0, ra, 1'b0, acc);
                check("R7 R3 random lookup", {31'd0, acc},
                      {31'd0, ra[40] & model[ref_word(ra)][ref_bit(ra)]});
            end
        end
        check_table("R5 R6 random table");

        read_word(0, d);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule